// File: doc/BRIEF.md
# Operand Resolver and Execute Unit

This block is the execute stage of a small 16-bit word machine. In each cycle it accepts an opcode and three raw operand words: a destination and two sources. Every raw word is classified as an immediate literal, a reference to one of eight internal registers, or an illegal code. The register file is held inside the block. The block runs one of nine arithmetic, logic, compare or move operations. Results are reduced to 15 bits.

The result appears one clock after the request, together with a valid strobe, the destination index, a write enable and an illegal flag. A legal result is written into the internal register file on the same edge that updates the outputs. The next request therefore sees the new value without a stall. Fetch, memory, stack, branch and terminal handling belong to neighbouring blocks.

Top module: `exec_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid`, `out_wen` and `out_illegal` are 0. Reset also clears all eight registers to zero.
- R2: A source raw word below 0x8000 is used as a literal value, unchanged.
- R3: A source raw word from 0x8000 to 0x8007 reads register (raw & 7). This is the value most recently written to that register.
- R4: A used source raw word of 0x8008 or above makes the result illegal. The illegal result has `out_illegal`=1, `out_wen`=0 and `out_value`=0, and no register changes.
- R5: A destination outside 0x8000..0x8007 makes the result illegal, with the same output values as R4 and no register write. `out_dest` always carries the destination's low three bits.
- R6: Opcode 4 writes 1 if the two sources are equal, else 0. Opcode 5 writes 1 if the first source is greater than the second (unsigned), else 0.
- R7: Opcode 9 (sum) and opcode 10 (product) write their result modulo 32768.
- R8: Opcode 11 writes the first source modulo the second. Opcode 12 writes their bitwise AND. Opcode 13 writes their bitwise OR.
- R9: Opcode 14 writes the bitwise inverse of its first source, masked to 15 bits.
- R10: Opcode 1 copies its first source into the destination register.
- R11: Opcode 11 with a second source equal to zero is illegal and writes nothing.
- R12: Opcodes 0, 2, 3, 6, 7, 8 and 15 to 31 are unsupported. They produce `out_illegal`=1 and write nothing.
- R13: A request with `in_valid`=1 gives `out_valid`=1 on the next cycle, with exactly one of `out_wen` or `out_illegal` set. With `in_valid`=0 the next cycle has all three strobes low and no register changes.
- R14: Opcodes 1 and 14 ignore the second source word entirely, even an illegal code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_opcode | input | 5 | Operation code |
| in_dst | input | 16 | Raw destination word |
| in_src_b | input | 16 | Raw first source word |
| in_src_c | input | 16 | Raw second source word |
| out_valid | output | 1 | Result of last cycle's request |
| out_dest | output | 3 | Destination register index |
| out_value | output | 16 | Result value (0 when illegal) |
| out_wen | output | 1 | Result was written to the register file |
| out_illegal | output | 1 | Request was rejected |

## Verification
The bench builds the block with its default sizes: 16-bit words and eight registers. With these sizes the whole opcode space of 32 codes is within reach. The bench crosses every opcode with fifteen source codes on each side. These codes cover the literal edges 0 and 0x7FFF, every register reference, and the first and last illegal codes. This cross exercises wrap-around, divide-by-zero and the ignored second source. Destination codes rotate through every register, a literal and an out-of-range code. Register contents build up through the sweep, so read-after-write forwarding through the internal file is covered as well.

// File: rtl/exec_pkg.sv
package exec_pkg;

    localparam int OPC_W = 5;

    localparam logic [OPC_W-1:0] OPC_MOVE = 5'd1;
    localparam logic [OPC_W-1:0] OPC_CMPEQ = 5'd4;
    localparam logic [OPC_W-1:0] OPC_CMPGT = 5'd5;
    localparam logic [OPC_W-1:0] OPC_SUM = 5'd9;
    localparam logic [OPC_W-1:0] OPC_PROD = 5'd10;
    localparam logic [OPC_W-1:0] OPC_REM = 5'd11;
    localparam logic [OPC_W-1:0] OPC_BAND = 5'd12;
    localparam logic [OPC_W-1:0] OPC_BOR = 5'd13;
    localparam logic [OPC_W-1:0] OPC_BINV = 5'd14;

    typedef enum logic [1:0] {
        KIND_LIT = 2'd0,
        KIND_REG = 2'd1,
        KIND_BAD = 2'd2
    } opnd_kind_e;

    typedef struct packed {
        logic valid;
        logic wen;
        logic illegal;
    } status_t;

    function automatic logic op_supported(input logic [OPC_W-1:0] op);
        case (op)
            OPC_MOVE, OPC_CMPEQ, OPC_CMPGT, OPC_SUM, OPC_PROD,
            OPC_REM, OPC_BAND, OPC_BOR, OPC_BINV: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic op_uses_second(input logic [OPC_W-1:0] op);
        return !(op == OPC_MOVE || op == OPC_BINV);
    endfunction

endpackage

// File: rtl/exec_opnd_resolve.sv
module exec_opnd_resolve
    import exec_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NREG = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [WORD_W-1:0]            raw,
    input  logic [NREG-1:0][WORD_W-1:0]  regs,
    output logic [WORD_W-1:0]            value,
    output opnd_kind_e                   kind,
    output logic [IDX_W-1:0]             idx
);
    localparam logic [WORD_W-1:0] LIT_LIMIT = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] REG_END = LIT_LIMIT + WORD_W'(NREG);

    always_comb begin
        idx = raw[IDX_W-1:0];
        if (raw < LIT_LIMIT) begin
            kind  = KIND_LIT;
            value = raw;
        end else if (raw < REG_END) begin
            kind  = KIND_REG;
            value = regs[idx];
        end else begin
            kind  = KIND_BAD;
            value = '0;
        end
    end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import exec_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [WORD_W-1:0] src_b,
    input  logic [WORD_W-1:0] src_c,
    output logic [WORD_W-1:0] result,
    output logic              div_zero
);
    localparam logic [WORD_W-1:0] VAL_MASK = {1'b0, {(WORD_W-1){1'b1}}};

    logic [2*WORD_W-1:0] product;
    logic [WORD_W-1:0]   sum;

    assign product = src_b * src_c;
    assign sum     = src_b + src_c;

    always_comb begin
        div_zero = 1'b0;
        result   = '0;
        case (opcode)
            OPC_MOVE:  result = src_b;
            OPC_CMPEQ: result = WORD_W'(src_b == src_c);
            OPC_CMPGT: result = WORD_W'(src_b > src_c);
            OPC_SUM:   result = sum & VAL_MASK;
            OPC_PROD:  result = product[WORD_W-1:0] & VAL_MASK;
            OPC_REM: begin
                div_zero = (src_c == '0);
                result   = div_zero ? '0 : (src_b % src_c);
            end
            OPC_BAND:  result = src_b & src_c;
            OPC_BOR:   result = src_b | src_c;
            OPC_BINV:  result = ~src_b & VAL_MASK;
            default:   result = '0;
        endcase
    end

endmodule

// File: rtl/exec_regfile.sv
module exec_regfile #(
    parameter int WORD_W = 16,
    parameter int NREG = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wen,
    input  logic [IDX_W-1:0]            widx,
    input  logic [WORD_W-1:0]           wdata,
    output logic [NREG-1:0][WORD_W-1:0] regs
);
    for (genvar g = 0; g < NREG; g++) begin : g_entry
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wen && widx == IDX_W'(g)) begin
                q <= wdata;
            end
        end
        assign regs[g] = q;
    end

endmodule

// File: rtl/exec_unit.sv
module exec_unit
    import exec_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NREG = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  in_opcode,
    input  logic [WORD_W-1:0] in_dst,
    input  logic [WORD_W-1:0] in_src_b,
    input  logic [WORD_W-1:0] in_src_c,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_dest,
    output logic [WORD_W-1:0] out_value,
    output logic              out_wen,
    output logic              out_illegal
);
    localparam int NOPND = 3;

    logic [NREG-1:0][WORD_W-1:0]  regs;
    logic [NOPND-1:0][WORD_W-1:0] raw;
    logic [NOPND-1:0][WORD_W-1:0] val;
    opnd_kind_e                   kind [NOPND];
    logic [NOPND-1:0][IDX_W-1:0]  idx;

    assign raw = {in_src_c, in_src_b, in_dst};

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        exec_opnd_resolve #(.WORD_W(WORD_W), .NREG(NREG)) u_res (
            .raw   (raw[g]),
            .regs  (regs),
            .value (val[g]),
            .kind  (kind[g]),
            .idx   (idx[g])
        );
    end

    logic [WORD_W-1:0] alu_res;
    logic              alu_dz;

    exec_alu #(.WORD_W(WORD_W)) u_alu (
        .opcode   (in_opcode),
        .src_b    (val[1]),
        .src_c    (val[2]),
        .result   (alu_res),
        .div_zero (alu_dz)
    );

    logic    reject;
    logic    two_src;
    status_t st_next;

    always_comb begin
        two_src = op_uses_second(in_opcode);
        reject  = !op_supported(in_opcode)
                || (kind[0] != KIND_REG)
                || (kind[1] == KIND_BAD)
                || (two_src && kind[2] == KIND_BAD)
                || alu_dz;
        st_next.valid   = in_valid;
        st_next.wen     = in_valid && !reject;
        st_next.illegal = in_valid && reject;
    end

    exec_regfile #(.WORD_W(WORD_W), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .wen   (st_next.wen),
        .widx  (idx[0]),
        .wdata (alu_res),
        .regs  (regs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_wen     <= 1'b0;
            out_illegal <= 1'b0;
            out_dest    <= '0;
            out_value   <= '0;
        end else begin
            out_valid   <= st_next.valid;
            out_wen     <= st_next.wen;
            out_illegal <= st_next.illegal;
            out_dest    <= idx[0];
            out_value   <= reject ? '0 : alu_res;
        end
    end

endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk
    import exec_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NREG = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OPC_W-1:0]  in_opcode,
    input logic [WORD_W-1:0] in_dst,
    input logic [WORD_W-1:0] in_src_b,
    input logic [WORD_W-1:0] out_value,
    input logic              out_valid,
    input logic              out_wen,
    input logic              out_illegal
);
    localparam logic [WORD_W-1:0] LIT_LIMIT = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] REG_END = LIT_LIMIT + WORD_W'(NREG);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_wen && !out_illegal));

    // R13
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_wen && !out_illegal));

    // R13
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_wen != out_illegal));

    // R5
    dest_range_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_dst < LIT_LIMIT || in_dst >= REG_END))
        |=> (out_illegal && !out_wen));

    // R4
    src_bad_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_src_b >= REG_END) |=> (out_illegal && out_value == '0));

    // R12
    opcode_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_supported(in_opcode)) |=> out_illegal);

    // R6
    cmp_range_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_opcode == OPC_CMPEQ || in_opcode == OPC_CMPGT))
        |=> (out_value <= WORD_W'(1)));

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        out_wen |-> (out_value < LIT_LIMIT));

endmodule

bind exec_unit exec_unit_chk #(.WORD_W(WORD_W), .NREG(NREG)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_opcode   (in_opcode),
    .in_dst      (in_dst),
    .in_src_b    (in_src_b),
    .out_value   (out_value),
    .out_valid   (out_valid),
    .out_wen     (out_wen),
    .out_illegal (out_illegal)
);

// File: tb/tb_exec_unit.sv
module tb_exec_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  in_opcode = '0;
    logic [15:0] in_dst = '0;
    logic [15:0] in_src_b = '0;
    logic [15:0] in_src_c = '0;
    logic        out_valid;
    logic [2:0]  out_dest;
    logic [15:0] out_value;
    logic        out_wen;
    logic        out_illegal;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] m [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    exec_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode),
        .in_dst(in_dst), .in_src_b(in_src_b), .in_src_c(in_src_c),
        .out_valid(out_valid), .out_dest(out_dest), .out_value(out_value),
        .out_wen(out_wen), .out_illegal(out_illegal)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic is_bad(input logic [15:0] r);
        return r >= 16'h8008;
    endfunction

    function automatic logic [15:0] rd(input logic [15:0] r);
        if (r < 16'h8000) return r;
        if (r < 16'h8008) return m[r[2:0]];
        return 16'h0;
    endfunction

    function automatic string tag_of(input logic [4:0] op, input logic [15:0] a,
                                     input logic [15:0] b, input logic [15:0] c);
        logic two;
        two = !(op == 5'd1 || op == 5'd14);
        if (is_bad(b) || (two && is_bad(c))) return "R4";
        if (a < 16'h8000 || a >= 16'h8008) return "R5";
        case (op)
            5'd1:  return is_bad(c) ? "R14" : "R10";
            5'd14: return is_bad(c) ? "R14" : "R9";
            5'd4, 5'd5: return "R6";
            5'd9, 5'd10: return "R7";
            5'd11: return (rd(c) == 16'h0) ? "R11" : "R8";
            5'd12, 5'd13: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic issue(input logic [4:0] op, input logic [15:0] a,
                         input logic [15:0] b, input logic [15:0] c, input string tag);
        logic two, supp, ill;
        logic [15:0] vb, vc, ev;
        int t;
        two  = !(op == 5'd1 || op == 5'd14);
        supp = (op == 1) || (op == 4) || (op == 5) || (op >= 9 && op <= 14);
        vb = rd(b);
        vc = rd(c);
        ill = !supp || a < 16'h8000 || a >= 16'h8008 || is_bad(b)
            || (two && is_bad(c)) || (op == 5'd11 && vc == 16'h0);
        ev = 16'h0;
        if (!ill) begin
            case (op)
                5'd1:  ev = vb;
                5'd4:  ev = (vb == vc) ? 16'd1 : 16'd0;
                5'd5:  ev = (vb > vc) ? 16'd1 : 16'd0;
                5'd9:  begin t = (int'(vb) + int'(vc)) % 32768; ev = t[15:0]; end
                5'd10: begin t = (int'(vb) * int'(vc)) % 32768; ev = t[15:0]; end
                5'd11: ev = vb % vc;
                5'd12: ev = vb & vc;
                5'd13: ev = vb | vc;
                default: ev = (~vb) & 16'h7fff;
            endcase
        end
        in_valid = 1'b1; in_opcode = op; in_dst = a; in_src_b = b; in_src_c = c;
        @(posedge clk); #1;
        in_valid = 1'b0;
        check(tag, {out_valid, out_wen, out_illegal, out_dest, out_value},
              {1'b1, !ill, ill, a[2:0], ev});
        if (!ill) m[a[2:0]] = ev;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    localparam int NPAT = 15;
    logic [15:0] pat [NPAT] = '{16'h0000, 16'h0001, 16'h0005, 16'h7fff, 16'h4000,
                               16'h8000, 16'h8001, 16'h8002, 16'h8003, 16'h8004,
                               16'h8005, 16'h8006, 16'h8007, 16'h8008, 16'hffff};

    initial begin
        for (int i = 0; i < 8; i++) m[i] = 16'h0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", {out_valid, out_wen, out_illegal}, 3'b000);
        rst = 1'b0;
        // R1: registers read back as zero after reset
        for (int i = 0; i < 8; i++) issue(5'd1, 16'h8000 + 16'(i), 16'h8000 + 16'(i), 16'h0, "R1");
        // R10, R2: literal copy
        for (int i = 0; i < 8; i++) issue(5'd1, 16'h8000 + 16'(i), 16'(100 * i + 3), 16'h0, "R10");
        issue(5'd1, 16'h8001, 16'h1234, 16'h0, "R2");
        // R3: register source sees previous write
        issue(5'd9, 16'h8002, 16'h8001, 16'h8001, "R3");
        // R7: wrap
        issue(5'd9, 16'h8003, 16'h7fff, 16'h0001, "R7");
        issue(5'd10, 16'h8004, 16'h4000, 16'h0002, "R7");
        // R11: divide by zero through a register holding zero
        issue(5'd11, 16'h8005, 16'h0009, 16'h8003, "R11");
        // R14: second word ignored
        issue(5'd14, 16'h8006, 16'h0f0f, 16'hffff, "R14");
        // R13: idle cycle with a write request pattern but no valid
        in_opcode = 5'd1; in_dst = 16'h8000; in_src_b = 16'h0777;
        @(posedge clk); #1;
        check("R13", {out_valid, out_wen, out_illegal}, 3'b000);
        issue(5'd1, 16'h8000, 16'h8000, 16'h0, "R13");
        // R12: unsupported opcode
        issue(5'd7, 16'h8000, 16'h0001, 16'h0001, "R12");
        // Sweep all opcodes against operand patterns
        begin
            int k;
            logic [15:0] a;
            k = 0;
            for (int op = 0; op < 32; op++) begin
                for (int ib = 0; ib < NPAT; ib++) begin
                    for (int ic = 0; ic < NPAT; ic++) begin
                        if (k % 10 == 9) a = 16'h8009;
                        else if (k % 10 == 8) a = 16'h0002;
                        else a = 16'h8000 + 16'(k % 8);
                        issue(5'(op), a, pat[ib], pat[ic], tag_of(5'(op), a, pat[ib], pat[ic]));
                        k++;
                    end
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule